// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer with Trap Entry

This block is the hard-wired control unit of a multicycle processor core. It holds a 4-bit state register. The register steps through instruction fetch, decode, execute, memory access and register write-back. In each state the block drives the strobes the datapath needs: memory read and write requests, instruction and data register loads, register-file write controls, ALU operation selects and PC update enables. The block handles six instruction classes: register-register ALU operations, OR with a zero-extended immediate, word load, word store, branch-if-equal and jump.

Memory accesses may take any number of cycles. The fetch state, the load-read state and the store-write state each stay put until the memory's ready input is high. The write strobes tied to those accesses fire only in the cycle the data is actually there.

There are three ways into the exception handler: an opcode the block does not recognise, a signed overflow reported by the ALU during a register-register operation, and the external interrupt line. The interrupt line is looked at only when an instruction retires. Each of these passes through a one-cycle trap state. That state raises `exc_enter` together with a cause code, so the datapath saves the PC and loads the handler vector. The next state is then fetch.

Top module: `mcyc_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `state_o` is 0000. `mem_rd` is 1, and `mem_wr`, `rf_we`, `ir_we` and `exc_enter` are 0.
- R2: In fetch (0000), `mem_rd` is 1. While `mem_ready` is 0 the state stays 0000 and `ir_we` and `pc_inc_we` stay 0. When `mem_ready` is 1, both strobes are 1 in that cycle and the next state is decode (0001).
- R3: Decode (0001) raises `ab_we` and `tgt_we`. It then moves on according to the 6-bit opcode: 0 to 0100, 13 to 0110, 35 to 1000, 43 to 1011, 4 to 0010, 2 to 0011.
- R4: The register-register execute state 0100 drives `alu_op`=10 (use the function field). Without overflow it is followed by 0101, which asserts `rf_we` with `rf_dst_rd`=1 and `rf_src_mem`=0. If `alu_ovf` is 1 in 0100, the next state is the overflow trap 1110 and no register write takes place. `alu_ovf` has no effect in any other state.
- R5: The OR-immediate execute state 0110 drives `alu_op`=11, `alu_imm`=1 and `imm_zext`=1. It is followed by 0111, which writes rt (`rf_we`=1, `rf_dst_rd`=0, `rf_src_mem`=0).
- R6: Load goes through 1000 (`alu_op`=00, `alu_imm`=1, `imm_zext`=0) and then 1001. In 1001, `mem_rd`=1 and the state holds until `mem_ready`. `mdr_we` is 1 only when `mem_ready` is 1. Next comes 1010, which writes rt from memory data (`rf_src_mem`=1, `rf_dst_rd`=0).
- R7: Store goes through 1011 and then 1100. In 1100, `mem_wr` stays 1 until `mem_ready`, and `rf_we` is 0.
- R8: The branch state 0010 drives `alu_op`=01 (subtract). It asserts `pc_br_we` exactly when `alu_zero` is 1.
- R9: The jump state 0011 asserts `pc_jmp_we`.
- R10: Any other opcode (for example 63 or 1) goes from decode to 1101, with `exc_enter`=1 and `exc_cause`=01.
- R11: `irq` is acted on only when leaving a final state: 0101, 0111, 1010, 0010, 0011, or 1100 with `mem_ready`. In that case the next state is 1111 with `exc_enter`=1 and `exc_cause`=11 instead of 0000. In every other state `irq` has no effect.
- R12: The trap states 1101, 1110 and 1111 last one cycle each and are always followed by 0000. `exc_enter` is 1 in those states only. The overflow trap reports `exc_cause`=10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | OP_W | Opcode field of the instruction register |
| alu_ovf | input | 1 | Signed overflow from the ALU |
| alu_zero | input | 1 | Operands equal (ALU result zero) |
| irq | input | 1 | External interrupt request |
| mem_ready | input | 1 | Memory has completed the current access |
| state_o | output | 4 | Current state code |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| ir_we | output | 1 | Load the instruction register |
| pc_inc_we | output | 1 | Write PC+4 into the PC |
| ab_we | output | 1 | Latch both source register values |
| tgt_we | output | 1 | Latch the computed branch target |
| alu_op | output | 2 | 00 add, 01 subtract, 10 function field, 11 OR |
| alu_imm | output | 1 | ALU second operand is the immediate |
| imm_zext | output | 1 | Zero-extend the immediate (else sign-extend) |
| s_we | output | 1 | Latch the ALU result |
| mdr_we | output | 1 | Latch memory read data |
| rf_we | output | 1 | Register-file write |
| rf_dst_rd | output | 1 | Destination is rd (else rt) |
| rf_src_mem | output | 1 | Write data from memory (else ALU result) |
| pc_br_we | output | 1 | Load the branch target into the PC |
| pc_jmp_we | output | 1 | Load the jump target into the PC |
| exc_enter | output | 1 | Save the PC and load the handler vector |
| exc_cause | output | 2 | 01 illegal opcode, 10 overflow, 11 interrupt |

## Verification
The bench builds the block with its default parameters: a 6-bit opcode and the six default opcode values. This leaves 58 opcode values that must reach the illegal-instruction trap, and the bench drives two of them (63 and 1). With these fixed encodings, every state code of the 4-bit register can be reached. The bench therefore walks each instruction class to its final state with zero and with several memory wait cycles. It raises the interrupt both in the middle of an instruction and at its end, and injects overflow both in the register-register execute state and in a load's address state.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

  typedef enum logic [3:0] {
    ST_FETCH  = 4'b0000,
    ST_DECODE = 4'b0001,
    ST_BR     = 4'b0010,
    ST_JMP    = 4'b0011,
    ST_R_EX   = 4'b0100,
    ST_R_WB   = 4'b0101,
    ST_ORI_EX = 4'b0110,
    ST_ORI_WB = 4'b0111,
    ST_LD_ADR = 4'b1000,
    ST_LD_MEM = 4'b1001,
    ST_LD_WB  = 4'b1010,
    ST_ST_ADR = 4'b1011,
    ST_ST_MEM = 4'b1100,
    ST_ILL    = 4'b1101,
    ST_OVF    = 4'b1110,
    ST_IRQ    = 4'b1111
  } state_e;

  typedef enum logic [2:0] {
    OC_R, OC_ORI, OC_LD, OC_ST, OC_BEQ, OC_JMP, OC_BAD
  } opcls_e;

  localparam logic [1:0] ALU_ADD = 2'b00;
  localparam logic [1:0] ALU_SUB = 2'b01;
  localparam logic [1:0] ALU_FN  = 2'b10;
  localparam logic [1:0] ALU_OR  = 2'b11;

  localparam logic [1:0] CAUSE_NONE = 2'b00;
  localparam logic [1:0] CAUSE_ILL  = 2'b01;
  localparam logic [1:0] CAUSE_OVF  = 2'b10;
  localparam logic [1:0] CAUSE_IRQ  = 2'b11;

  typedef struct packed {
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_ld;
    logic       pc_inc;
    logic       ab_ld;
    logic       tgt_ld;
    logic [1:0] alu_op;
    logic       alu_imm;
    logic       imm_zext;
    logic       s_ld;
    logic       mdr_ld;
    logic       rf_we;
    logic       rf_dst_rd;
    logic       rf_src_mem;
    logic       br;
    logic       jmp;
    logic       exc;
    logic [1:0] cause;
  } ctl_t;

endpackage

// File: rtl/mcyc_opdec.sv
module mcyc_opdec
  import mcyc_pkg::*;
#(
  parameter int OP_W = 6,
  parameter logic [OP_W-1:0] OPC_R   = 0,
  parameter logic [OP_W-1:0] OPC_ORI = 13,
  parameter logic [OP_W-1:0] OPC_LD  = 35,
  parameter logic [OP_W-1:0] OPC_ST  = 43,
  parameter logic [OP_W-1:0] OPC_BEQ = 4,
  parameter logic [OP_W-1:0] OPC_JMP = 2
) (
  input  logic [OP_W-1:0] opcode,
  output opcls_e          cls
);
  always_comb begin
    if      (opcode == OPC_R)   cls = OC_R;
    else if (opcode == OPC_ORI) cls = OC_ORI;
    else if (opcode == OPC_LD)  cls = OC_LD;
    else if (opcode == OPC_ST)  cls = OC_ST;
    else if (opcode == OPC_BEQ) cls = OC_BEQ;
    else if (opcode == OPC_JMP) cls = OC_JMP;
    else                        cls = OC_BAD;
  end
endmodule

// File: rtl/mcyc_nxt.sv
module mcyc_nxt
  import mcyc_pkg::*;
(
  input  state_e cur,
  input  opcls_e cls,
  input  logic   ovf,
  input  logic   irq,
  input  logic   ready,
  output state_e nxt
);
  state_e retire;

  // instruction boundary: the only point where the interrupt line matters
  assign retire = irq ? ST_IRQ : ST_FETCH;

  always_comb begin
    nxt = ST_FETCH;
    unique case (cur)
      ST_FETCH:  nxt = ready ? ST_DECODE : ST_FETCH;
      ST_DECODE: begin
        unique case (cls)
          OC_R:    nxt = ST_R_EX;
          OC_ORI:  nxt = ST_ORI_EX;
          OC_LD:   nxt = ST_LD_ADR;
          OC_ST:   nxt = ST_ST_ADR;
          OC_BEQ:  nxt = ST_BR;
          OC_JMP:  nxt = ST_JMP;
          default: nxt = ST_ILL;
        endcase
      end
      ST_R_EX:   nxt = ovf ? ST_OVF : ST_R_WB;
      ST_ORI_EX: nxt = ST_ORI_WB;
      ST_LD_ADR: nxt = ST_LD_MEM;
      ST_LD_MEM: nxt = ready ? ST_LD_WB : ST_LD_MEM;
      ST_ST_ADR: nxt = ST_ST_MEM;
      ST_ST_MEM: nxt = ready ? retire : ST_ST_MEM;
      ST_R_WB, ST_ORI_WB, ST_LD_WB, ST_BR, ST_JMP: nxt = retire;
      ST_ILL, ST_OVF, ST_IRQ: nxt = ST_FETCH;
      default:   nxt = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/mcyc_ctlrom.sv
module mcyc_ctlrom
  import mcyc_pkg::*;
(
  input  state_e st,
  output ctl_t   ctl
);
  always_comb begin
    ctl = '0;
    ctl.alu_op = ALU_ADD;
    ctl.cause  = CAUSE_NONE;
    unique case (st)
      ST_FETCH:  begin ctl.mem_rd = 1'b1; ctl.ir_ld = 1'b1; ctl.pc_inc = 1'b1; end
      ST_DECODE: begin ctl.ab_ld = 1'b1; ctl.tgt_ld = 1'b1;
                       ctl.alu_imm = 1'b1; end
      ST_R_EX:   begin ctl.alu_op = ALU_FN; ctl.s_ld = 1'b1; end
      ST_R_WB:   begin ctl.rf_we = 1'b1; ctl.rf_dst_rd = 1'b1; end
      ST_ORI_EX: begin ctl.alu_op = ALU_OR; ctl.alu_imm = 1'b1;
                       ctl.imm_zext = 1'b1; ctl.s_ld = 1'b1; end
      ST_ORI_WB: ctl.rf_we = 1'b1;
      ST_LD_ADR, ST_ST_ADR: begin ctl.alu_imm = 1'b1; ctl.s_ld = 1'b1; end
      ST_LD_MEM: begin ctl.mem_rd = 1'b1; ctl.mdr_ld = 1'b1; end
      ST_LD_WB:  begin ctl.rf_we = 1'b1; ctl.rf_src_mem = 1'b1; end
      ST_ST_MEM: ctl.mem_wr = 1'b1;
      ST_BR:     begin ctl.alu_op = ALU_SUB; ctl.br = 1'b1; end
      ST_JMP:    ctl.jmp = 1'b1;
      ST_ILL:    begin ctl.exc = 1'b1; ctl.cause = CAUSE_ILL; end
      ST_OVF:    begin ctl.exc = 1'b1; ctl.cause = CAUSE_OVF; end
      ST_IRQ:    begin ctl.exc = 1'b1; ctl.cause = CAUSE_IRQ; end
      default:   ctl = '0;
    endcase
  end
endmodule

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
  import mcyc_pkg::*;
#(
  parameter int OP_W = 6,
  parameter logic [OP_W-1:0] OPC_R   = 0,
  parameter logic [OP_W-1:0] OPC_ORI = 13,
  parameter logic [OP_W-1:0] OPC_LD  = 35,
  parameter logic [OP_W-1:0] OPC_ST  = 43,
  parameter logic [OP_W-1:0] OPC_BEQ = 4,
  parameter logic [OP_W-1:0] OPC_JMP = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  input  logic            alu_ovf,
  input  logic            alu_zero,
  input  logic            irq,
  input  logic            mem_ready,
  output logic [3:0]      state_o,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            ir_we,
  output logic            pc_inc_we,
  output logic            ab_we,
  output logic            tgt_we,
  output logic [1:0]      alu_op,
  output logic            alu_imm,
  output logic            imm_zext,
  output logic            s_we,
  output logic            mdr_we,
  output logic            rf_we,
  output logic            rf_dst_rd,
  output logic            rf_src_mem,
  output logic            pc_br_we,
  output logic            pc_jmp_we,
  output logic            exc_enter,
  output logic [1:0]      exc_cause
);
  opcls_e cls;
  state_e state_q, state_d;
  ctl_t   ctl_d, ctl_q;

  mcyc_opdec #(
    .OP_W(OP_W), .OPC_R(OPC_R), .OPC_ORI(OPC_ORI), .OPC_LD(OPC_LD),
    .OPC_ST(OPC_ST), .OPC_BEQ(OPC_BEQ), .OPC_JMP(OPC_JMP)
  ) u_dec (
    .opcode(opcode),
    .cls   (cls)
  );

  mcyc_nxt u_nxt (
    .cur  (state_q),
    .cls  (cls),
    .ovf  (alu_ovf),
    .irq  (irq),
    .ready(mem_ready),
    .nxt  (state_d)
  );

  // control word looked up for the upcoming state, then registered
  mcyc_ctlrom u_rom (
    .st (state_d),
    .ctl(ctl_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_FETCH;
      ctl_q   <= '0;
      ctl_q.mem_rd <= 1'b1;
      ctl_q.ir_ld  <= 1'b1;
      ctl_q.pc_inc <= 1'b1;
    end else begin
      state_q <= state_d;
      ctl_q   <= ctl_d;
    end
  end

  assign state_o    = state_q;
  assign mem_rd     = ctl_q.mem_rd;
  assign mem_wr     = ctl_q.mem_wr;
  assign ir_we      = ctl_q.ir_ld  & mem_ready;
  assign pc_inc_we  = ctl_q.pc_inc & mem_ready;
  assign ab_we      = ctl_q.ab_ld;
  assign tgt_we     = ctl_q.tgt_ld;
  assign alu_op     = ctl_q.alu_op;
  assign alu_imm    = ctl_q.alu_imm;
  assign imm_zext   = ctl_q.imm_zext;
  assign s_we       = ctl_q.s_ld;
  assign mdr_we     = ctl_q.mdr_ld & mem_ready;
  assign rf_we      = ctl_q.rf_we;
  assign rf_dst_rd  = ctl_q.rf_dst_rd;
  assign rf_src_mem = ctl_q.rf_src_mem;
  assign pc_br_we   = ctl_q.br & alu_zero;
  assign pc_jmp_we  = ctl_q.jmp;
  assign exc_enter  = ctl_q.exc;
  assign exc_cause  = ctl_q.cause;

  a_r2_fetch_hold: assert property (@(posedge clk) disable iff (rst)
    (state_o == 4'b0000 && !mem_ready) |=> state_o == 4'b0000);

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (state_o == 4'b0100 && alu_ovf) |=> (state_o == 4'b1110 && !rf_we));

  a_r6_mdr_needs_ready: assert property (@(posedge clk) disable iff (rst)
    mdr_we |-> (mem_ready && state_o == 4'b1001));

  a_r7_store_no_rf: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (!rf_we && state_o == 4'b1100));

  a_r11_irq_boundary: assert property (@(posedge clk) disable iff (rst)
    (state_o inside {4'b0000, 4'b0001, 4'b0100, 4'b0110, 4'b1000, 4'b1011})
      |=> state_o != 4'b1111);

  a_r12_trap_to_fetch: assert property (@(posedge clk) disable iff (rst)
    exc_enter |=> (state_o == 4'b0000 && !exc_enter));

endmodule

// File: tb/mcyc_ctrl_tb_top.sv
module mcyc_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = '0;
  logic       alu_ovf = 1'b0, alu_zero = 1'b0, irq = 1'b0, mem_ready = 1'b1;
  logic [3:0] state_o;
  logic mem_rd, mem_wr, ir_we, pc_inc_we, ab_we, tgt_we, alu_imm, imm_zext;
  logic s_we, mdr_we, rf_we, rf_dst_rd, rf_src_mem, pc_br_we, pc_jmp_we, exc_enter;
  logic [1:0] alu_op, exc_cause;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  mcyc_ctrl dut_i (
    .clk(clk), .rst(rst), .opcode(opcode), .alu_ovf(alu_ovf), .alu_zero(alu_zero),
    .irq(irq), .mem_ready(mem_ready), .state_o(state_o), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .ir_we(ir_we), .pc_inc_we(pc_inc_we), .ab_we(ab_we),
    .tgt_we(tgt_we), .alu_op(alu_op), .alu_imm(alu_imm), .imm_zext(imm_zext),
    .s_we(s_we), .mdr_we(mdr_we), .rf_we(rf_we), .rf_dst_rd(rf_dst_rd),
    .rf_src_mem(rf_src_mem), .pc_br_we(pc_br_we), .pc_jmp_we(pc_jmp_we),
    .exc_enter(exc_enter), .exc_cause(exc_cause)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // advance to just after the next rising edge; inputs are changed here
  task automatic nxt();
    @(posedge clk);
    #2;
  endtask

  task automatic settle();
    #1;
  endtask

  // entered in a fetch cycle; leaves in the cycle after decode
  task automatic do_fetch(input logic [5:0] op, input int waits);
    for (int i = 0; i < waits; i++) begin
      mem_ready = 1'b0; settle();
      chk("R2 fetch holds", state_o, 4'b0000);
      chk("R2 no ir_we while waiting", ir_we, 0);
      chk("R2 no pc_inc_we while waiting", pc_inc_we, 0);
      nxt();
    end
    mem_ready = 1'b1; opcode = op; settle();
    chk("R2 fetch state", state_o, 4'b0000);
    chk("R2 mem_rd in fetch", mem_rd, 1);
    chk("R2 ir_we on ready", ir_we, 1);
    chk("R2 pc_inc_we on ready", pc_inc_we, 1);
    nxt(); settle();
    chk("R3 decode state", state_o, 4'b0001);
    chk("R3 ab_we", ab_we, 1);
    chk("R3 tgt_we", tgt_we, 1);
    nxt();
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #2; settle();
    chk("R1 state in reset", state_o, 4'b0000);
    chk("R1 mem_rd in reset", mem_rd, 1);
    rst = 1'b0; settle();
    chk("R1 state after reset", state_o, 4'b0000);
    chk("R1 mem_wr", mem_wr, 0);
    chk("R1 rf_we", rf_we, 0);
    chk("R1 exc_enter", exc_enter, 0);
    mem_ready = 1'b0; settle();
    chk("R1 ir_we", ir_we, 0);
    mem_ready = 1'b1;
  endtask

  task automatic t_rtype(input logic ovf, input int waits);
    do_fetch(6'd0, waits);
    alu_ovf = ovf; settle();
    chk("R3 R-type dispatch", state_o, 4'b0100);
    chk("R4 alu_op function", alu_op, 2'b10);
    chk("R4 s_we", s_we, 1);
    nxt(); alu_ovf = 1'b0; settle();
    if (ovf) begin
      chk("R4 overflow trap state", state_o, 4'b1110);
      chk("R4 no rf_we on overflow", rf_we, 0);
      chk("R12 exc_enter overflow", exc_enter, 1);
      chk("R12 cause overflow", exc_cause, 2'b10);
    end else begin
      chk("R4 write-back state", state_o, 4'b0101);
      chk("R4 rf_we", rf_we, 1);
      chk("R4 rf_dst_rd", rf_dst_rd, 1);
      chk("R4 rf_src_mem", rf_src_mem, 0);
    end
    nxt(); settle();
    chk("R12 back to fetch", state_o, 4'b0000);
    chk("R12 exc_enter low in fetch", exc_enter, 0);
  endtask

  task automatic t_ori(input logic irq_mid, input logic irq_end);
    do_fetch(6'd13, 0);
    irq = irq_mid; settle();
    chk("R3 ORI dispatch", state_o, 4'b0110);
    chk("R5 alu_op or", alu_op, 2'b11);
    chk("R5 alu_imm", alu_imm, 1);
    chk("R5 imm_zext", imm_zext, 1);
    nxt(); irq = irq_end; settle();
    chk("R11 irq mid-instruction ignored", state_o, 4'b0111);
    chk("R5 rf_we", rf_we, 1);
    chk("R5 rf_dst_rd rt", rf_dst_rd, 0);
    chk("R11 no exc mid-instruction", exc_enter, 0);
    nxt(); settle();
    if (irq_end) begin
      chk("R11 irq entry state", state_o, 4'b1111);
      chk("R11 exc_enter", exc_enter, 1);
      chk("R11 cause irq", exc_cause, 2'b11);
      nxt(); settle();
      chk("R12 irq trap then fetch", state_o, 4'b0000);
      chk("R12 exc_enter drops", exc_enter, 0);
      irq = 1'b0;
    end else begin
      chk("R5 back to fetch", state_o, 4'b0000);
    end
  endtask

  task automatic t_load(input int waits);
    do_fetch(6'd35, 0);
    alu_ovf = 1'b1; settle();
    chk("R3 load dispatch", state_o, 4'b1000);
    chk("R6 alu_imm", alu_imm, 1);
    chk("R6 sign extend", imm_zext, 0);
    chk("R6 alu_op add", alu_op, 2'b00);
    nxt(); alu_ovf = 1'b0;
    for (int i = 0; i < waits; i++) begin
      mem_ready = 1'b0; settle();
      chk("R6 load read holds", state_o, 4'b1001);
      chk("R6 mdr_we low while waiting", mdr_we, 0);
      chk("R6 mem_rd", mem_rd, 1);
      nxt();
    end
    mem_ready = 1'b1; settle();
    chk("R4 overflow ignored in load address", state_o, 4'b1001);
    chk("R6 mdr_we on ready", mdr_we, 1);
    nxt(); settle();
    chk("R6 load write-back", state_o, 4'b1010);
    chk("R6 rf_we", rf_we, 1);
    chk("R6 rf_src_mem", rf_src_mem, 1);
    chk("R6 rf_dst_rd rt", rf_dst_rd, 0);
    nxt(); settle();
    chk("R6 back to fetch", state_o, 4'b0000);
  endtask

  task automatic t_store(input int waits, input logic irq_end);
    do_fetch(6'd43, 1);
    settle();
    chk("R3 store dispatch", state_o, 4'b1011);
    nxt();
    irq = irq_end;
    for (int i = 0; i < waits; i++) begin
      mem_ready = 1'b0; settle();
      chk("R7 store holds", state_o, 4'b1100);
      chk("R7 mem_wr held", mem_wr, 1);
      chk("R7 no rf_we", rf_we, 0);
      nxt();
    end
    mem_ready = 1'b1; settle();
    chk("R7 store state", state_o, 4'b1100);
    chk("R7 mem_wr", mem_wr, 1);
    nxt(); settle();
    if (irq_end) begin
      chk("R11 irq after store", state_o, 4'b1111);
      chk("R11 cause irq", exc_cause, 2'b11);
      irq = 1'b0;
      nxt(); settle();
    end
    chk("R7 back to fetch", state_o, 4'b0000);
    chk("R7 mem_wr released", mem_wr, 0);
  endtask

  task automatic t_beq(input logic zero);
    do_fetch(6'd4, 0);
    alu_zero = zero; settle();
    chk("R3 branch dispatch", state_o, 4'b0010);
    chk("R8 alu_op sub", alu_op, 2'b01);
    chk("R8 pc_br_we follows zero", pc_br_we, zero);
    nxt(); alu_zero = 1'b0; settle();
    chk("R8 back to fetch", state_o, 4'b0000);
    chk("R8 pc_br_we low in fetch", pc_br_we, 0);
  endtask

  task automatic t_jmp();
    do_fetch(6'd2, 0);
    settle();
    chk("R3 jump dispatch", state_o, 4'b0011);
    chk("R9 pc_jmp_we", pc_jmp_we, 1);
    nxt(); settle();
    chk("R9 back to fetch", state_o, 4'b0000);
    chk("R9 pc_jmp_we low", pc_jmp_we, 0);
  endtask

  task automatic t_illegal(input logic [5:0] op);
    do_fetch(op, 0);
    settle();
    chk("R10 illegal trap state", state_o, 4'b1101);
    chk("R10 exc_enter", exc_enter, 1);
    chk("R10 cause illegal", exc_cause, 2'b01);
    chk("R10 no rf_we", rf_we, 0);
    nxt(); settle();
    chk("R12 illegal trap then fetch", state_o, 4'b0000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    t_reset();
    t_rtype(1'b0, 0);
    t_rtype(1'b0, 3);
    t_rtype(1'b1, 0);
    t_ori(1'b0, 1'b0);
    t_ori(1'b1, 1'b1);
    t_load(0);
    t_load(4);
    t_store(0, 1'b0);
    t_store(2, 1'b1);
    t_beq(1'b1);
    t_beq(1'b0);
    t_jmp();
    t_illegal(6'd63);
    t_illegal(6'd1);
    t_rtype(1'b0, 0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule